// File: doc/BRIEF.md
# Fly-by Peripheral-to-Memory DMA Channel

This block is one DMA channel that moves words from a peripheral into memory with no help from the processor. Before a transfer the processor loads three things through a small write port: a start address, a word count and a release mode. When the peripheral raises its request, the channel asks the processor for the buses with a hold request. It waits for hold acknowledge, and then runs fly-by word cycles. In each word cycle the channel drives the memory address, the memory write strobe and the acknowledge to the peripheral, and the peripheral puts its data straight onto the data bus. So each word takes one memory cycle and never passes through the channel.

The mode sets when the buses are handed back. Single mode gives them back after every word. Block mode keeps them for the whole count. Demand mode keeps them while the peripheral holds its request. Cycle-stealing mode hands them back after every word and asks again on its own, so processor cycles and DMA cycles alternate. When the count runs out, a done flag is set and an optional one-clock interrupt pulse is raised.

Top module: `flyby_dma_chan`

## Requirements
- R1: After reset, hold_req, bus_oe, mem_wr, periph_ack, done and irq are low and mem_addr is zero. The stored address, count and mode are zero (mode zero is single).
- R2: A programming write (cfg_we high) is accepted only while the channel is idle. cfg_sel 0 loads the address, 1 loads the count, and 2 loads the mode from cfg_wdata[1:0]. The mode codes are 0 single, 1 block, 2 demand and 3 cycle-stealing. A write made while a transfer is under way, up to and including the cycle that returns to idle, changes nothing.
- R3: When periph_req is seen high while idle with a non-zero count, hold_req is high in the next cycle. No word cycle happens until hold_ack is high.
- R4: A word cycle lasts one clock. In it mem_wr, periph_ack and bus_oe are high and mem_addr equals the current address. After the word cycle the address goes up by one and the count goes down by one.
- R5: Whenever bus_oe is low, mem_wr and periph_ack are low and mem_addr is zero.
- R6: In single mode each bus tenure carries exactly one word. A count of N therefore takes N separate hold_req tenures, each started by a request.
- R7: In block mode one request moves the whole count in one tenure, with the word cycles in consecutive clocks.
- R8: In demand mode another word follows only if periph_req is high at the end of the current word cycle. Otherwise the bus is released and the rest of the count waits for a new request.
- R9: In cycle-stealing mode, hold_req drops after every word. Once hold_ack has gone low, the channel raises hold_req again without a new request, until the count is zero.
- R10: hold_req is low in the clock after the last word cycle of a tenure. The channel starts nothing new until hold_ack has gone low.
- R11: done and a one-clock irq pulse appear in the clock after the word cycle that brings the count to zero. done stays high until the next accepted programming write clears it.
- R12: While the count is zero, a request is ignored and hold_req stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| cfg_we | input | 1 | Programming write strobe |
| cfg_sel | input | 2 | Programming target: 0 address, 1 count, 2 mode |
| cfg_wdata | input | PROG_W | Programming write data |
| periph_req | input | 1 | Transfer request from the peripheral |
| periph_ack | output | 1 | Acknowledge to the peripheral during a word cycle |
| hold_req | output | 1 | Bus hold request to the processor |
| hold_ack | input | 1 | Bus hold acknowledge from the processor |
| mem_addr | output | ADDR_W | Memory address, zero when not driving |
| mem_wr | output | 1 | Memory write strobe |
| bus_oe | output | 1 | Output enable for address and strobe drivers |
| done | output | 1 | Transfer complete flag |
| irq | output | 1 | One-clock interrupt pulse at completion |

## Verification
Two events can fall in the same clock: a programming write from the processor, and the final word cycle that empties the count. The bench provokes this by putting a count write on the port in exactly the clock where it sees the last write strobe. It then judges that the write was dropped: done must still be high afterwards, and a later request must not start a transfer, because the count is still zero. A second overlap is in demand mode, where the request falls in the same clock as a word cycle. The bench checks that exactly that word completes and that the bus is then released.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;

    // Release policy loaded through the programming port (cfg_wdata[1:0])
    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_DEMAND = 2'd2,
        XM_STEAL  = 2'd3
    } xfer_mode_e;

    // Channel sequencer states
    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ARB     = 2'd1,
        SQ_MOVE    = 2'd2,
        SQ_RELEASE = 2'd3
    } seq_state_e;

    // Programming register selector values
    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_MODE  = 2'd2;

endpackage

// File: rtl/dma_prog_regs.sv
module dma_prog_regs
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PROG_W = 16,
    parameter bit IRQ_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PROG_W-1:0] cfg_wdata,
    input  logic              busy,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cnt_zero_o,
    output logic              cnt_one_o,
    output xfer_mode_e        mode_o,
    output logic              done_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        xfer_mode_e        mode;
        logic              done;
        logic              irq;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.irq = 1'b0;
        if (cfg_we && !busy) begin
            r_d.done = 1'b0;
            unique case (cfg_sel)
                SEL_ADDR:  r_d.addr = cfg_wdata[ADDR_W-1:0];
                SEL_COUNT: r_d.cnt  = cfg_wdata[CNT_W-1:0];
                SEL_MODE:  r_d.mode = xfer_mode_e'(cfg_wdata[1:0]);
                default:   ;
            endcase
        end
        if (step) begin
            r_d.addr = r_q.addr + ADDR_W'(1);
            r_d.cnt  = r_q.cnt - CNT_ONE;
            if (r_q.cnt == CNT_ONE) begin
                r_d.done = 1'b1;
                r_d.irq  = IRQ_EN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o     = r_q.addr;
    assign cnt_zero_o = (r_q.cnt == '0);
    assign cnt_one_o  = (r_q.cnt == CNT_ONE);
    assign mode_o     = r_q.mode;
    assign done_o     = r_q.done;

    generate
        if (IRQ_EN) begin : g_irq
            assign irq_o = r_q.irq;
        end else begin : g_no_irq
            assign irq_o = 1'b0;
        end
    endgenerate

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_o == $past(addr_o) + ADDR_W'(1)));

    // R11
    irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> done_o);

    // R11
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R2
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_o));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import flyby_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       periph_req,
    input  logic       hold_ack,
    input  xfer_mode_e mode,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    output logic       hold_req,
    output logic       word_cycle,
    output logic       busy
);

    typedef struct packed {
        seq_state_e state;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            SQ_IDLE: begin
                if (periph_req && !cnt_zero) s_d.state = SQ_ARB;
            end
            SQ_ARB: begin
                if (hold_ack) s_d.state = SQ_MOVE;
            end
            SQ_MOVE: begin
                if (cnt_one) begin
                    s_d.state = SQ_RELEASE;
                end else begin
                    unique case (mode)
                        XM_BLOCK:  s_d.state = SQ_MOVE;
                        XM_DEMAND: s_d.state = periph_req ? SQ_MOVE : SQ_RELEASE;
                        default:   s_d.state = SQ_RELEASE;
                    endcase
                end
            end
            SQ_RELEASE: begin
                if (!hold_ack) begin
                    if (mode == XM_STEAL && !cnt_zero) s_d.state = SQ_ARB;
                    else                               s_d.state = SQ_IDLE;
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: SQ_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign hold_req   = (s_q.state == SQ_ARB) || (s_q.state == SQ_MOVE);
    assign word_cycle = (s_q.state == SQ_MOVE);
    assign busy       = (s_q.state != SQ_IDLE);

    // R3
    grant_before_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_cycle |-> hold_ack);

    // R10
    release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_cycle && cnt_one) |=> !hold_req);

    // R10
    wait_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == SQ_RELEASE && hold_ack) |=> (!word_cycle && !hold_req));

    // R12
    zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cnt_zero) |=> !hold_req);

endmodule

// File: rtl/dma_bus_drv.sv
module dma_bus_drv #(
    parameter int ADDR_W = 16
) (
    input  logic              word_cycle,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              periph_ack,
    output logic              bus_oe
);

    always_comb begin
        bus_oe     = word_cycle;
        mem_wr     = word_cycle;
        periph_ack = word_cycle;
        mem_addr   = word_cycle ? addr_in : '0;
    end

endmodule

// File: rtl/flyby_dma_chan.sv
module flyby_dma_chan
    import flyby_dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter bit IRQ_EN = 1'b1,
    localparam int PROG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [PROG_W-1:0] cfg_wdata,
    input  logic              periph_req,
    output logic              periph_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              bus_oe,
    output logic              done,
    output logic              irq
);

    logic              busy;
    logic              word_cycle;
    logic              cnt_zero;
    logic              cnt_one;
    logic [ADDR_W-1:0] cur_addr;
    xfer_mode_e        mode;

    dma_prog_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PROG_W (PROG_W),
        .IRQ_EN (IRQ_EN)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .step       (word_cycle),
        .addr_o     (cur_addr),
        .cnt_zero_o (cnt_zero),
        .cnt_one_o  (cnt_one),
        .mode_o     (mode),
        .done_o     (done),
        .irq_o      (irq)
    );

    dma_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .periph_req (periph_req),
        .hold_ack   (hold_ack),
        .mode       (mode),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .hold_req   (hold_req),
        .word_cycle (word_cycle),
        .busy       (busy)
    );

    dma_bus_drv #(
        .ADDR_W (ADDR_W)
    ) u_drv (
        .word_cycle (word_cycle),
        .addr_in    (cur_addr),
        .mem_addr   (mem_addr),
        .mem_wr     (mem_wr),
        .periph_ack (periph_ack),
        .bus_oe     (bus_oe)
    );

endmodule

// File: tb/test_flyby_dma_chan.sv
module test_flyby_dma_chan;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        periph_req = 1'b0;
    logic        hold_ack = 1'b0;
    logic        cpu_sticky = 1'b0;
    logic        periph_ack, hold_req, mem_wr, bus_oe, done, irq;
    logic [15:0] mem_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_strobe = 0;
    int rises = 0;
    int irq_cnt = 0;
    int last_cyc = 0;
    int max_gap = 0;
    int min_gap = 1000;
    logic prev_hr = 1'b0;
    logic prev_irq = 1'b0;
    logic [15:0] exp_q[$];

    flyby_dma_chan i_flyby_dma_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .periph_req (periph_req),
        .periph_ack (periph_ack),
        .hold_req   (hold_req),
        .hold_ack   (hold_ack),
        .mem_addr   (mem_addr),
        .mem_wr     (mem_wr),
        .bus_oe     (bus_oe),
        .done       (done),
        .irq        (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Processor model: grants one clock after the request, releases one clock after it drops
    initial begin
        forever begin
            @(posedge clk);
            cyc <= cyc + 1;
            hold_ack <= hold_req || (cpu_sticky && hold_ack);
        end
    end

    // Monitor: pops expected addresses and checks bus behaviour
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (mem_wr) begin
                    if (n_strobe > 0) begin
                        if (cyc - last_cyc > max_gap) max_gap = cyc - last_cyc;
                        if (cyc - last_cyc < min_gap) min_gap = cyc - last_cyc;
                    end
                    last_cyc = cyc;
                    n_strobe++;
                    check(hold_ack && periph_ack && bus_oe, "R3", "word cycle without grant/ack", 0, 1);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4", "unexpected word at address", int'(mem_addr), 0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        check(mem_addr == e, "R4", "word address", int'(mem_addr), int'(e));
                    end
                end
                if (!bus_oe && (mem_wr || periph_ack || mem_addr != 16'd0))
                    check(1'b0, "R5", "outputs active without bus_oe", int'(mem_addr), 0);
                if (hold_req && !prev_hr) rises++;
                if (irq) begin
                    irq_cnt++;
                    if (prev_irq) check(1'b0, "R11", "irq wider than one clock", 2, 1);
                end
                prev_hr  = hold_req;
                prev_irq = irq;
            end
        end
    end

    task automatic prog(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic [1:0] m);
        prog(2'd0, a);
        prog(2'd1, n);
        prog(2'd2, {14'd0, m});
        for (int i = 0; i < int'(n); i++) exp_q.push_back(a + 16'(i));
        n_strobe = 0; rises = 0; irq_cnt = 0; max_gap = 0; min_gap = 1000;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    endtask

    task automatic wait_strobes(input int k);
        int c;
        c = 0;
        for (int i = 0; i < 400 && c < k; i++) begin
            @(negedge clk);
            if (mem_wr) c++;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk);
        periph_req = 1'b1;
        @(negedge clk);
        periph_req = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!hold_req && !bus_oe && !mem_wr && !periph_ack, "R1", "bus outputs after reset", 1, 0);
        check(!done && !irq && mem_addr == 16'd0, "R1", "done/irq/addr after reset", int'(done), 0);

        // R12 zero count: request ignored
        periph_req = 1'b1;
        repeat (6) @(negedge clk);
        check(!hold_req && rises == 0, "R12", "hold_req rises with zero count", rises, 0);
        periph_req = 1'b0;

        // R7 block mode, R3 request timing, R10/R11 completion
        setup(16'h0100, 16'd4, 2'd1);
        @(negedge clk);
        periph_req = 1'b1;
        @(negedge clk);
        periph_req = 1'b0;
        check(hold_req == 1'b1, "R3", "hold_req one clock after request", int'(hold_req), 1);
        check(bus_oe == 1'b0, "R3", "bus driven before grant", int'(bus_oe), 0);
        wait_done();
        check(done == 1'b1, "R11", "done after block", int'(done), 1);
        check(hold_req == 1'b0, "R10", "hold_req after last word", int'(hold_req), 0);
        repeat (3) @(negedge clk);
        check(rises == 1, "R7", "block tenures", rises, 1);
        check(n_strobe == 4, "R7", "block words", n_strobe, 4);
        check(max_gap == 1, "R7", "block words back to back", max_gap, 1);
        check(irq_cnt == 1, "R11", "irq pulses", irq_cnt, 1);

        // R2 busy writes ignored, including one in the final word clock
        setup(16'h0500, 16'd3, 2'd1);
        check(done == 1'b0, "R11", "done cleared by programming write", int'(done), 0);
        pulse_req();
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h0900;
        @(negedge clk);
        cfg_we = 1'b0;
        wait_strobes(3);
        cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 16'd7;
        @(negedge clk);
        cfg_we = 1'b0;
        check(done == 1'b1, "R2", "write in final word clock cleared done", int'(done), 1);
        repeat (6) @(negedge clk);
        periph_req = 1'b1;
        repeat (6) @(negedge clk);
        periph_req = 1'b0;
        check(rises == 1, "R2", "count reloaded by busy write", rises, 1);
        check(n_strobe == 3, "R2", "words after ignored writes", n_strobe, 3);

        // R6 single mode with a slow release from the processor (R10)
        setup(16'h0200, 16'd3, 2'd0);
        cpu_sticky = 1'b1;
        @(negedge clk);
        periph_req = 1'b1;
        wait_strobes(1);
        repeat (6) @(negedge clk);
        check(n_strobe == 1, "R10", "word started before hold_ack fell", n_strobe, 1);
        check(hold_req == 1'b0 && hold_ack == 1'b1, "R10", "hold_req while ack still high", int'(hold_req), 0);
        cpu_sticky = 1'b0;
        wait_done();
        periph_req = 1'b0;
        repeat (3) @(negedge clk);
        check(rises == 3, "R6", "single-mode tenures", rises, 3);
        check(n_strobe == 3, "R6", "single-mode words", n_strobe, 3);

        // R8 demand mode: request dropped in a word clock
        setup(16'h0300, 16'd6, 2'd2);
        @(negedge clk);
        periph_req = 1'b1;
        wait_strobes(2);
        periph_req = 1'b0;
        repeat (6) @(negedge clk);
        check(n_strobe == 2, "R8", "words before request dropped", n_strobe, 2);
        check(!hold_req && !done, "R8", "bus kept or done early", int'(hold_req), 0);
        periph_req = 1'b1;
        wait_done();
        periph_req = 1'b0;
        repeat (3) @(negedge clk);
        check(n_strobe == 6, "R8", "demand words total", n_strobe, 6);
        check(rises == 2, "R8", "demand tenures", rises, 2);

        // R9 cycle stealing
        setup(16'h0400, 16'd3, 2'd3);
        pulse_req();
        wait_done();
        repeat (3) @(negedge clk);
        check(n_strobe == 3, "R9", "steal words", n_strobe, 3);
        check(rises == 3, "R9", "steal tenures", rises, 3);
        check(min_gap > 1, "R9", "words not separated", min_gap, 2);
        check(irq_cnt == 1, "R11", "steal irq pulses", irq_cnt, 1);

        // R11 done cleared by the next accepted write
        prog(2'd2, 16'd0);
        check(done == 1'b0, "R11", "done after idle write", int'(done), 0);
        check(exp_q.size() == 0, "R4", "expected words left over", exp_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule